// File: doc/BRIEF.md
# Programmable Parallel Peripheral Port

This block gives a processor three byte-wide parallel ports (A, B and C) and a control register, all reached through a small register bus. A control word sets the direction and operating mode of two port groups. Group A is port A plus the upper nibble of port C. Group B is port B plus the lower nibble of port C. A control word can instead set or clear one port C bit. In simple mode, inputs are read live from the pins and outputs hold the last value written. In strobed mode, ports A and B each become a handshaked byte port. The matching nibble of port C then carries the strobe or acknowledge input, the buffer-full and interrupt outputs, and a readable status nibble.

Pads are modelled as separate in, out and output-enable vectors. The bus is a plain register interface and not a stream. A cycle with `cs` and `wr` high is one write. A cycle with `cs` and `rd` high is one read. Every access is accepted in the cycle it is presented, so there is no back-pressure and no ready signal. Read data is valid combinationally during the read cycle. The side effects of a read take place at the clock edge that ends that cycle. The handshake pins are sampled on the block clock.

Top module: `pport_ctrl`

## Requirements
- R1: After reset all three ports are inputs with every output-enable low. All output latches are zero, and every buffer-full, interrupt and interrupt-enable flag is clear.
- R2: A control write with D7=1 and D6=0 is a mode word, laid out as follows. D5 selects strobed mode for group A. D4 makes port A an input. D3 makes the upper port C nibble an input. D2 selects strobed mode for group B. D1 makes port B an input. D0 makes the lower port C nibble an input. An output port drives all of its enables high. A mode word also clears all output latches and all flags.
- R3: A control write with D7=1 and D6=1 asks for bidirectional mode. It is ignored: directions, modes, latches and pins all stay as they were.
- R4: A control write with D7=0 writes D0 into the port C latch bit numbered by D3..D1. Bit 4 also sets the interrupt enable of group A, and bit 0 also sets the interrupt enable of group B.
- R5: A simple-mode input port reads back the live pin value each time.
- R6: A simple-mode output port drives its latch onto its pins. A read of that port returns the latch.
- R7: In simple mode each port C nibble has its own direction. A read of port C returns pins for an input nibble and the latch for an output nibble.
- R8: Strobed input: while the strobe pin is low, the port data is captured and buffer-full is set. A read of the port returns the captured byte. That read clears buffer-full and the interrupt.
- R9: Strobed input: when the strobe pin rises, the interrupt is raised only if the group's interrupt enable is 1.
- R10: Strobed output: a port write asserts buffer-full and clears the interrupt. A low acknowledge clears buffer-full. When the acknowledge rises, the interrupt is raised if the enable is 1.
- R11: In strobed mode a group's nibble has fixed roles. Nibble bit 0 is the strobe or acknowledge input. Bit 1 drives buffer-full. Bit 2 drives the interrupt. Bit 3 remains a general line in the nibble's direction. Group A uses PC7..PC4 and group B uses PC3..PC0.
- R12: In strobed mode a read of port C returns one status nibble per group: {general bit, interrupt, buffer-full, interrupt enable}, from bit 3 down to bit 0.
- R13: Register select 0, 1, 2 and 3 address port A, port B, port C and control. A strobe without `cs` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select for bus accesses |
| rd | input | 1 | Read strobe, one access per cycle |
| wr | input | 1 | Write strobe, one access per cycle |
| sel | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero outside a read |
| pa_in | input | 8 | Port A pad input |
| pa_out | output | 8 | Port A pad output |
| pa_oe | output | 8 | Port A pad output enable |
| pb_in | input | 8 | Port B pad input |
| pb_out | output | 8 | Port B pad output |
| pb_oe | output | 8 | Port B pad output enable |
| pc_in | input | 8 | Port C pad input |
| pc_out | output | 8 | Port C pad output |
| pc_oe | output | 8 | Port C pad output enable |

## Verification
The assertions check these rules on every cycle. A low strobe sets buffer-full. A read of a strobed input port clears its flags. A write of a strobed output port sets buffer-full, and a low acknowledge clears it. A bidirectional mode word leaves the configuration untouched. A mode word zeroes every pad output. Only the bench scenarios can show the rest. These are the bit layout of mode and bit commands, the live versus latched read values, the port C pin roles, the status nibble contents, and the rule that a rising strobe raises the interrupt only when its enable is set.

// File: rtl/pport_pkg.sv
package pport_pkg;

  localparam logic [1:0] SEL_A   = 2'd0;
  localparam logic [1:0] SEL_B   = 2'd1;
  localparam logic [1:0] SEL_C   = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  typedef struct packed {
    logic a_strb;  // group A strobed
    logic a_in;    // port A input
    logic cu_in;   // port C upper nibble input
    logic b_strb;  // group B strobed
    logic b_in;    // port B input
    logic cl_in;   // port C lower nibble input
  } pp_cfg_t;

  localparam pp_cfg_t CFG_RST = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};

endpackage

// File: rtl/pport_cfg.sv
module pport_cfg
  import pport_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          pc_wr,
  input  logic [DW-1:0] wdata,
  output pp_cfg_t       cfg,
  output logic          mode_clr,
  output logic [DW-1:0] pc_lat,
  output logic [1:0]    inte
);
  localparam int NW = DW / 2;
  localparam int BW = $clog2(DW);

  logic          bit_cmd;
  logic [BW-1:0] bsel;
  pp_cfg_t       nxt;

  assign mode_clr = ctl_wr & wdata[7] & ~wdata[6];
  assign bit_cmd  = ctl_wr & ~wdata[7];
  assign bsel     = wdata[BW:1];
  assign nxt      = '{wdata[5], wdata[4], wdata[3], wdata[2], wdata[1], wdata[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= CFG_RST;
      pc_lat <= '0;
      inte   <= '0;
    end else if (mode_clr) begin
      cfg    <= nxt;
      pc_lat <= '0;
      inte   <= '0;
    end else if (bit_cmd) begin
      pc_lat[bsel] <= wdata[0];
      if (bsel == BW'(NW)) inte[1] <= wdata[0];
      if (bsel == '0)      inte[0] <= wdata[0];
    end else if (pc_wr) begin
      pc_lat <= wdata;
    end
  end

  p_bidir_rejected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[7] && wdata[6]) |=> ($stable(cfg) && $stable(pc_lat) && $stable(inte)));

endmodule

// File: rtl/pport_hs.sv
module pport_hs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          dir_in,
  input  logic          inte,
  input  logic          hs_pin,
  input  logic          rd_hit,
  input  logic          wr_hit,
  input  logic [DW-1:0] pin_data,
  output logic [DW-1:0] cap,
  output logic          full,
  output logic          intr
);
  logic hs_q;
  logic rise;

  assign rise = hs_pin & ~hs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b1;
      full <= 1'b0;
      intr <= 1'b0;
      cap  <= '0;
    end else begin
      hs_q <= hs_pin;
      if (clr || !en) begin
        full <= 1'b0;
        intr <= 1'b0;
      end else if (dir_in) begin
        if (!hs_pin) begin
          cap  <= pin_data;
          full <= 1'b1;
        end else if (rd_hit) begin
          full <= 1'b0;
        end
        if (rise)        intr <= intr | inte;
        else if (rd_hit) intr <= 1'b0;
      end else begin
        if (!hs_pin)     full <= 1'b0;
        else if (wr_hit) full <= 1'b1;
        if (rise)        intr <= intr | inte;
        else if (wr_hit) intr <= 1'b0;
      end
    end
  end

  p_stb_sets_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dir_in && !hs_pin && !clr) |=> full);

  p_read_clears_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dir_in && hs_pin && hs_q && rd_hit && !clr) |=> (!full && !intr));

  p_write_sets_obf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dir_in && hs_pin && hs_q && wr_hit && !clr) |=> (full && !intr));

  p_ack_clears_obf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dir_in && !hs_pin && !clr) |=> !full);

endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe
);
  localparam int NW = DW / 2;

  pp_cfg_t              cfg;
  logic                 mode_clr;
  logic [DW-1:0]        pc_lat;
  logic [1:0]           inte;
  logic                 rd_cyc, wr_cyc;
  logic [1:0]           g_strb, g_pdir, g_ndir;
  logic [1:0][DW-1:0]   g_pin, lat_g, rdv_g;
  logic [DW-1:0]        pc_rd;

  assign rd_cyc = cs & rd;
  assign wr_cyc = cs & wr;

  // group 1 = A (upper C nibble), group 0 = B (lower C nibble)
  assign g_strb = {cfg.a_strb, cfg.b_strb};
  assign g_pdir = {cfg.a_in,   cfg.b_in};
  assign g_ndir = {cfg.cu_in,  cfg.cl_in};
  assign g_pin  = {pa_in, pb_in};

  pport_cfg #(.DW(DW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (wr_cyc && sel == SEL_CTL),
    .pc_wr    (wr_cyc && sel == SEL_C),
    .wdata    (wdata),
    .cfg      (cfg),
    .mode_clr (mode_clr),
    .pc_lat   (pc_lat),
    .inte     (inte)
  );

  for (genvar g = 0; g < 2; g++) begin : g_grp
    localparam logic [1:0] MYSEL = (g == 1) ? SEL_A : SEL_B;
    localparam int         BASE  = g * NW;

    logic          rd_hit, wr_hit;
    logic [DW-1:0] lat, cap;
    logic          full, intr;
    logic [NW-1:0] nib_out, nib_oe, gen_v, stat;

    assign rd_hit = rd_cyc && sel == MYSEL;
    assign wr_hit = wr_cyc && sel == MYSEL;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lat <= '0;
      else if (mode_clr) lat <= '0;
      else if (wr_hit)   lat <= wdata;
    end

    pport_hs #(.DW(DW)) u_hs (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (mode_clr),
      .en       (g_strb[g]),
      .dir_in   (g_pdir[g]),
      .inte     (inte[g]),
      .hs_pin   (pc_in[BASE]),
      .rd_hit   (rd_hit),
      .wr_hit   (wr_hit),
      .pin_data (g_pin[g]),
      .cap      (cap),
      .full     (full),
      .intr     (intr)
    );

    assign gen_v = g_ndir[g] ? pc_in[BASE +: NW] : pc_lat[BASE +: NW];

    always_comb begin
      if (g_strb[g]) begin
        nib_out = {pc_lat[BASE+NW-1 : BASE+3], intr, full, 1'b0};
        nib_oe  = {{(NW-3){~g_ndir[g]}}, 1'b1, 1'b1, 1'b0};
        stat    = {gen_v[NW-1:3], intr, full, inte[g]};
      end else begin
        nib_out = pc_lat[BASE +: NW];
        nib_oe  = {NW{~g_ndir[g]}};
        stat    = gen_v;
      end
    end

    assign pc_out[BASE +: NW] = nib_out;
    assign pc_oe[BASE +: NW]  = nib_oe;
    assign pc_rd[BASE +: NW]  = stat;
    assign lat_g[g] = lat;
    assign rdv_g[g] = (g_strb[g] && g_pdir[g]) ? cap :
                      g_pdir[g]                ? g_pin[g] : lat;
  end

  assign pa_out = lat_g[1];
  assign pb_out = lat_g[0];
  assign pa_oe  = {DW{~cfg.a_in}};
  assign pb_oe  = {DW{~cfg.b_in}};

  always_comb begin
    rdata = '0;
    if (rd_cyc) begin
      case (sel)
        SEL_A:   rdata = rdv_g[1];
        SEL_B:   rdata = rdv_g[0];
        SEL_C:   rdata = pc_rd;
        default: rdata = '0;
      endcase
    end
  end

  p_modeset_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_clr |=> (pa_out == '0 && pb_out == '0 && pc_out == '0));

endmodule

// File: tb/tb_pport_ctrl.sv
`timescale 1ns/100ps
module tb_pport_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h11;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pport_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .sel(sel),
    .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] s, input logic [7:0] d, input logic c = 1'b1);
    @(negedge clk);
    cs = c; wr = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; sel = s;
    #1 d = rdata;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pc_oe", pc_oe, 8'h00);
    chk("R1 pa_out", pa_out, 8'h00);
    chk("R1 pc_out", pc_out, 8'h00);
  endtask

  task automatic t_simple();
    logic [7:0] d;
    bus_wr(2'd3, 8'h80);
    chk("R2 pa_oe out", pa_oe, 8'hFF);
    chk("R2 pc_oe out", pc_oe, 8'hFF);
    bus_wr(2'd0, 8'h5A);
    chk("R6 pa_out", pa_out, 8'h5A);
    bus_rd(2'd0, d);
    chk("R6 read latch", d, 8'h5A);
    bus_wr(2'd1, 8'h3E);
    chk("R6 pb_out", pb_out, 8'h3E);
    bus_wr(2'd3, 8'h93);
    chk("R2 latch cleared", pa_out, 8'h00);
    chk("R2 pa_oe in", pa_oe, 8'h00);
    chk("R7 pc_oe split", pc_oe, 8'hF0);
    pa_in = 8'h3C;
    bus_rd(2'd0, d);
    chk("R5 live read", d, 8'h3C);
    pa_in = 8'hC3;
    bus_rd(2'd0, d);
    chk("R5 live read 2", d, 8'hC3);
    bus_wr(2'd2, 8'hA5);
    chk("R7 pc upper out", {4'h0, pc_out[7:4]}, 8'h0A);
    pc_in = 8'h06;
    bus_rd(2'd2, d);
    chk("R7 pc mixed read", d, 8'hA6);
    pc_in = 8'h11;
  endtask

  task automatic t_bitcmd();
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd3, 8'h0B);
    chk("R4 set bit5", pc_out, 8'h20);
    bus_wr(2'd3, 8'h07);
    chk("R4 set bit3", pc_out, 8'h28);
    bus_wr(2'd3, 8'h0A);
    chk("R4 clear bit5", pc_out, 8'h08);
  endtask

  task automatic t_reject();
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'h11);
    bus_wr(2'd0, 8'h22, 1'b0);
    chk("R13 no cs no write", pa_out, 8'h11);
    bus_wr(2'd1, 8'h44);
    chk("R13 sel1 is port B", pb_out, 8'h44);
    bus_wr(2'd3, 8'hC0);
    chk("R3 latch kept", pa_out, 8'h11);
    chk("R3 dir kept", pa_oe, 8'hFF);
    bus_wr(2'd3, 8'hF3);
    chk("R3 second reject", pb_oe, 8'hFF);
  endtask

  task automatic t_strb_in();
    logic [7:0] d;
    bus_wr(2'd3, 8'hB4);
    chk("R11 pc_oe roles", pc_oe, 8'hEE);
    bus_wr(2'd3, 8'h09);
    pa_in = 8'h77;
    @(negedge clk); pc_in[4] = 1'b0;
    @(negedge clk); pc_in[4] = 1'b1;
    chk("R8 ibf set", {7'h0, pc_out[5]}, 8'h01);
    pa_in = 8'h00;
    @(negedge clk);
    chk("R9 intr raised", {7'h0, pc_out[6]}, 8'h01);
    bus_rd(2'd2, d);
    chk("R12 status", d, 8'h70);
    bus_rd(2'd0, d);
    chk("R8 captured data", d, 8'h77);
    chk("R8 ibf cleared", {7'h0, pc_out[5]}, 8'h00);
    chk("R8 intr cleared", {7'h0, pc_out[6]}, 8'h00);
    bus_wr(2'd3, 8'h08);
    @(negedge clk); pc_in[4] = 1'b0;
    @(negedge clk); pc_in[4] = 1'b1;
    @(negedge clk);
    chk("R9 no intr when disabled", {6'h0, pc_out[6:5]}, 8'h01);
  endtask

  task automatic t_strb_out();
    logic [7:0] d;
    bus_wr(2'd3, 8'h01);
    bus_wr(2'd1, 8'h9C);
    chk("R10 pb_out", pb_out, 8'h9C);
    chk("R10 pb_oe", pb_oe, 8'hFF);
    chk("R10 obf set", {7'h0, pc_out[1]}, 8'h01);
    @(negedge clk); pc_in[0] = 1'b0;
    @(negedge clk); pc_in[0] = 1'b1;
    chk("R10 ack clears obf", {7'h0, pc_out[1]}, 8'h00);
    @(negedge clk);
    chk("R10 intr on ack rise", {7'h0, pc_out[2]}, 8'h01);
    bus_rd(2'd2, d);
    chk("R12 status B", {4'h0, d[3:0]}, 8'h05);
    bus_wr(2'd1, 8'h01);
    chk("R10 write clears intr", {6'h0, pc_out[2:1]}, 8'h01);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_simple();
    t_bitcmd();
    t_reject();
    t_strb_in();
    t_strb_out();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule